// File: doc/BRIEF.md
# Serial flash read sequencer

This block converts one memory-mapped read request into a complete read transaction on a serial NOR flash. A request carries a byte address and a byte count. The sequencer then runs, in order, an instruction phase, an address phase, an optional mode-byte phase, a dummy phase, an optional turnaround beat and a data phase. It returns the received bytes on a valid/ready stream. Each clock cycle in which `sck_en` is high is one serial clock beat. A neighbouring block turns those beats into the divided serial clock and the chip-select timing, so `cs_act` only marks the span of the transaction.

All configuration is static while a request is in flight. The configuration selects one of six read flavours, the address length, the dummy count, an opcode substitution and a mode byte. It also selects continuous-read (XIP) operation, in which later I/O-mode reads omit the instruction byte, and an optional turnaround beat before data that arrives on several lines. Output enables are driven per I/O line.

Top module: `sfr_seq`

## Requirements
- R1: Line usage per flavour (`cfg_mode`): 0 standard, 1 fast, 2 dual output, 3 dual I/O, 4 quad output, 5 quad I/O. Codes 6 and 7 are prohibited. The instruction always goes out on one line. The address and mode byte use 2 lines in mode 3, 4 lines in mode 5 and 1 line otherwise. Data uses 2 lines in modes 2 and 3, 4 lines in modes 4 and 5, and 1 line otherwise. Single-line output is on `io_out[0]`, with `io_oe` = 0001. Dual output is on `io_out[1:0]`, with `io_oe` = 0011. Quad output is on `io_out[3:0]`, with `io_oe` = 1111. The higher line carries the more significant bit, and every field goes out MSB first. Single-line data is sampled from `io_in[1]`.
- R2: Default opcodes are 03h, 0Bh, 3Bh, BBh, 6Bh and EBh for modes 0 to 5 respectively.
- R3: When `cfg_addr_bytes` = 3 (4-byte address) and `cfg_op_4b` = 1, the opcodes become 13h, 0Ch, 3Ch, BCh, 6Ch and ECh instead.
- R4: When `cfg_op_sub` = 1, `cfg_opcode` is sent in place of any default opcode.
- R5: The address phase sends the low `cfg_addr_bytes`+1 bytes of `req_addr`, most significant byte first.
- R6: The standard read has no dummy beats. Otherwise a `cfg_dummy` code of 0 gives the flavour's default: 8 for modes 1, 2 and 4, 0 for mode 3 and 4 for mode 5. A nonzero code n gives n+2 beats.
- R7: Modes 3 and 5 send `cfg_mode_byte` right after the address, on the address lines.
- R8: `xip_active` is updated when a read completes. It becomes 1 if that read was an I/O mode with `cfg_xip_en` = 1, and 0 otherwise. An I/O-mode read that starts while `xip_active` = 1 has no instruction phase.
- R9: With `cfg_turnaround` = 1, one beat with no output enable is inserted before data in modes 2 to 5. In modes 0 and 1 it has no effect.
- R10: `io_oe` is all zero from the first dummy beat, or the first non-driven beat, through the end of the data phase.
- R11: Exactly `req_len`+1 bytes are returned in order on `rd_valid`/`rd_data`. While a byte waits unaccepted, no beat runs and the byte is held.
- R12: `busy` rises with request acceptance and stays high until the last byte is accepted. `req_ready` is low while busy. `cs_act` and `sck_en` stay low outside a transaction.
- R13: After reset the block is idle: `busy`, `cs_act`, `rd_valid` and `xip_active` are 0, `io_oe` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial beat per enabled cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Read flavour select |
| cfg_addr_bytes | input | 2 | Address length minus one, in bytes |
| cfg_op_4b | input | 1 | Use the 4-byte-address opcode variant |
| cfg_op_sub | input | 1 | Send `cfg_opcode` instead of the default opcode |
| cfg_opcode | input | 8 | Substitute opcode |
| cfg_dummy | input | DUMMY_W | Dummy code (0 selects the default) |
| cfg_mode_byte | input | 8 | Mode byte for I/O reads |
| cfg_xip_en | input | 1 | Permit continuous-read mode |
| cfg_turnaround | input | 1 | Insert a turnaround beat before multi-line data |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted when high |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Byte count minus one |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Consumer accepts the byte |
| rd_data | output | 8 | Read byte |
| cs_act | output | 1 | Transaction in progress on the serial bus |
| sck_en | output | 1 | A serial beat runs in this cycle |
| io_out | output | 4 | Serial line output values |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Serial line input values |
| busy | output | 1 | Request accepted and not yet fully delivered |
| xip_active | output | 1 | Continuous-read mode is in effect |

## Verification
The bench targets the beat bookkeeping. It covers a 1-byte address on two lines, a dummy code of 0 in dual I/O mode (no dummy at all), and turnaround requested in single-data modes. A design that miscounted would show a wrong total beat count or a shifted data byte. The bench follows XIP across a sequence of I/O reads, then a quad-output read, then a re-enabled read. A wrong update rule would either skip an instruction it needed or send one the flash does not expect. Opcode priority is checked with substitution and the 4-byte variant requested together. Random consumer backpressure on a long quad read exposes any beat that runs while a byte is still waiting, because that byte would be lost or its bits shifted.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   typedef enum logic [2:0] {
      PH_IDLE, PH_CMD, PH_ADDR, PH_MODE, PH_DUMMY, PH_GAP, PH_DATA
   } phase_e;

   // lane count encoded as log2: 0 one line, 1 two lines, 2 four lines
   typedef logic [1:0] lane_log_t;
   typedef logic [7:0] beat_t;

   typedef struct packed {
      logic [7:0] opcode;
      logic [7:0] mode_byte;
      beat_t      cmd_beats;
      beat_t      addr_beats;
      beat_t      mode_beats;
      beat_t      dummy_beats;
      logic       gap;
      logic       xip_next;
      lane_log_t  addr_lanes;
      lane_log_t  data_lanes;
   } plan_t;

   function automatic logic [3:0] lane_mask(lane_log_t l);
      case (l)
         2'd0:    return 4'b0001;
         2'd1:    return 4'b0011;
         default: return 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/sfr_plan.sv
module sfr_plan
   import sfr_pkg::*;
#(
   parameter int DUMMY_W = 3
) (
   input  logic [2:0]         cfg_mode,
   input  logic [1:0]         cfg_addr_bytes,
   input  logic               cfg_op_4b,
   input  logic               cfg_op_sub,
   input  logic [7:0]         cfg_opcode,
   input  logic [DUMMY_W-1:0] cfg_dummy,
   input  logic [7:0]         cfg_mode_byte,
   input  logic               cfg_xip_en,
   input  logic               cfg_turnaround,
   input  logic               xip_now,
   output plan_t              plan
);

   logic [7:0] base_op, wide_op;
   beat_t      dflt_dummy;
   lane_log_t  alog, dlog;
   logic       io_kind, no_dummy;

   always_comb begin
      base_op    = 8'h03;
      wide_op    = 8'h13;
      dflt_dummy = 8'd0;
      alog       = 2'd0;
      dlog       = 2'd0;
      io_kind    = 1'b0;
      no_dummy   = 1'b1;
      case (cfg_mode)
         3'd1: begin base_op = 8'h0B; wide_op = 8'h0C; dflt_dummy = 8'd8; no_dummy = 1'b0; end
         3'd2: begin base_op = 8'h3B; wide_op = 8'h3C; dflt_dummy = 8'd8; no_dummy = 1'b0;
                     dlog = 2'd1; end
         3'd3: begin base_op = 8'hBB; wide_op = 8'hBC; dflt_dummy = 8'd0; no_dummy = 1'b0;
                     alog = 2'd1; dlog = 2'd1; io_kind = 1'b1; end
         3'd4: begin base_op = 8'h6B; wide_op = 8'h6C; dflt_dummy = 8'd8; no_dummy = 1'b0;
                     dlog = 2'd2; end
         3'd5: begin base_op = 8'hEB; wide_op = 8'hEC; dflt_dummy = 8'd4; no_dummy = 1'b0;
                     alog = 2'd2; dlog = 2'd2; io_kind = 1'b1; end
         default: ;
      endcase

      if (cfg_op_sub)
         plan.opcode = cfg_opcode;
      else if (cfg_addr_bytes == 2'd3 && cfg_op_4b)
         plan.opcode = wide_op;
      else
         plan.opcode = base_op;

      plan.mode_byte   = cfg_mode_byte;
      plan.cmd_beats   = (io_kind && xip_now) ? 8'd0 : 8'd8;
      plan.addr_beats  = ({6'd0, cfg_addr_bytes} + 8'd1) << (2'd3 - alog);
      plan.mode_beats  = io_kind ? (8'd8 >> alog) : 8'd0;
      if (no_dummy)
         plan.dummy_beats = 8'd0;
      else if (cfg_dummy == '0)
         plan.dummy_beats = dflt_dummy;
      else
         plan.dummy_beats = 8'(cfg_dummy) + 8'd2;
      plan.gap         = cfg_turnaround && (dlog != 2'd0);
      plan.xip_next    = io_kind && cfg_xip_en;
      plan.addr_lanes  = alog;
      plan.data_lanes  = dlog;
   end

endmodule

// File: rtl/sfr_txser.sv
module sfr_txser
   import sfr_pkg::*;
#(
   parameter int SR_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [SR_W-1:0] load_val,
   input  logic            shift,
   input  lane_log_t       lanes,
   output logic [3:0]      out_bits
);

   logic [SR_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr <= '0;
      else if (load)
         sr <= load_val;
      else if (shift)
         sr <= sr << (1 << lanes);
   end

   always_comb begin
      case (lanes)
         2'd0:    out_bits = {3'b000, sr[SR_W-1]};
         2'd1:    out_bits = {2'b00, sr[SR_W-1 -: 2]};
         default: out_bits = sr[SR_W-1 -: 4];
      endcase
   end

endmodule

// File: rtl/sfr_rxdes.sv
module sfr_rxdes
   import sfr_pkg::*;
#(
   parameter int SOLO_LINE = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       shift,
   input  lane_log_t  lanes,
   input  logic [3:0] io_in,
   output logic [7:0] byte_next
);

   logic [7:0] acc;
   logic       solo_bit;

   generate
      if (SOLO_LINE < 0 || SOLO_LINE > 3) begin : g_bad_line
         $error("sfr_rxdes: SOLO_LINE out of range");
      end
   endgenerate

   assign solo_bit = io_in[SOLO_LINE];

   always_comb begin
      case (lanes)
         2'd0:    byte_next = {acc[6:0], solo_bit};
         2'd1:    byte_next = {acc[5:0], io_in[1:0]};
         default: byte_next = {acc[3:0], io_in};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (shift)
         acc <= byte_next;
   end

endmodule

// File: rtl/sfr_seq.sv
module sfr_seq
   import sfr_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 8,
   parameter int DUMMY_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         cfg_mode,
   input  logic [1:0]         cfg_addr_bytes,
   input  logic               cfg_op_4b,
   input  logic               cfg_op_sub,
   input  logic [7:0]         cfg_opcode,
   input  logic [DUMMY_W-1:0] cfg_dummy,
   input  logic [7:0]         cfg_mode_byte,
   input  logic               cfg_xip_en,
   input  logic               cfg_turnaround,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [LEN_W-1:0]   req_len,
   output logic               rd_valid,
   input  logic               rd_ready,
   output logic [7:0]         rd_data,
   output logic               cs_act,
   output logic               sck_en,
   output logic [3:0]         io_out,
   output logic [3:0]         io_oe,
   input  logic [3:0]         io_in,
   output logic               busy,
   output logic               xip_active
);

   localparam int SR_W = 32;

   generate
      if (ADDR_W < 8 || ADDR_W > SR_W) begin : g_bad_addr
         $error("sfr_seq: ADDR_W must lie in 8..32");
      end
      if (DUMMY_W < 1 || DUMMY_W > 6) begin : g_bad_dummy
         $error("sfr_seq: DUMMY_W must lie in 1..6");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("sfr_seq: LEN_W must be positive");
      end
   endgenerate

   phase_e           phase, nxt_ph;
   plan_t            plan_c, plan_q, plan_s;
   beat_t            beats_left;
   logic [LEN_W-1:0] bytes_left;
   logic [SR_W-1:0]  addr_q, addr_left, load_val;
   logic             rd_valid_q, xip_q, accept, beat, driven, phase_end, tx_load;
   logic [7:0]       rd_data_q, rx_next;
   logic [3:0]       tx_bits;
   lane_log_t        tx_lanes;

   function automatic phase_e after_addr(plan_t pl);
      if (pl.dummy_beats != 8'd0) return PH_DUMMY;
      if (pl.gap)                 return PH_GAP;
      return PH_DATA;
   endfunction

   function automatic phase_e next_phase(phase_e p, plan_t pl);
      case (p)
         PH_IDLE:  return (pl.cmd_beats != 8'd0) ? PH_CMD : PH_ADDR;
         PH_CMD:   return PH_ADDR;
         PH_ADDR:  return (pl.mode_beats != 8'd0) ? PH_MODE : after_addr(pl);
         PH_MODE:  return after_addr(pl);
         PH_DUMMY: return pl.gap ? PH_GAP : PH_DATA;
         default:  return PH_DATA;
      endcase
   endfunction

   function automatic beat_t beats_of(phase_e p, plan_t pl);
      case (p)
         PH_CMD:   return pl.cmd_beats;
         PH_ADDR:  return pl.addr_beats;
         PH_MODE:  return pl.mode_beats;
         PH_DUMMY: return pl.dummy_beats;
         PH_GAP:   return 8'd1;
         default:  return 8'd8 >> pl.data_lanes;
      endcase
   endfunction

   sfr_plan #(.DUMMY_W(DUMMY_W)) u_plan (
      .cfg_mode       (cfg_mode),
      .cfg_addr_bytes (cfg_addr_bytes),
      .cfg_op_4b      (cfg_op_4b),
      .cfg_op_sub     (cfg_op_sub),
      .cfg_opcode     (cfg_opcode),
      .cfg_dummy      (cfg_dummy),
      .cfg_mode_byte  (cfg_mode_byte),
      .cfg_xip_en     (cfg_xip_en),
      .cfg_turnaround (cfg_turnaround),
      .xip_now        (xip_q),
      .plan           (plan_c)
   );

   assign plan_s    = (phase == PH_IDLE) ? plan_c : plan_q;
   assign busy      = (phase != PH_IDLE) || rd_valid_q;
   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;
   assign cs_act    = (phase != PH_IDLE);
   assign sck_en    = cs_act && !(phase == PH_DATA && rd_valid_q && !rd_ready);
   assign beat      = sck_en;
   assign driven    = (phase == PH_CMD) || (phase == PH_ADDR) || (phase == PH_MODE);
   assign phase_end = accept || (beat && phase != PH_DATA && beats_left == 8'd1);
   assign nxt_ph    = next_phase(phase, plan_s);
   assign addr_left = SR_W'(req_addr) << {~cfg_addr_bytes, 3'b000};
   assign tx_load   = phase_end &&
                      (nxt_ph == PH_CMD || nxt_ph == PH_ADDR || nxt_ph == PH_MODE);
   assign tx_lanes  = (phase == PH_CMD) ? 2'd0 : plan_q.addr_lanes;

   always_comb begin
      case (nxt_ph)
         PH_CMD:  load_val = {plan_s.opcode, 24'd0};
         PH_ADDR: load_val = accept ? addr_left : addr_q;
         default: load_val = {plan_s.mode_byte, 24'd0};
      endcase
   end

   sfr_txser #(.SR_W(SR_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tx_load),
      .load_val (load_val),
      .shift    (beat && driven),
      .lanes    (tx_lanes),
      .out_bits (tx_bits)
   );

   sfr_rxdes #(.SOLO_LINE(1)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift     (beat && phase == PH_DATA),
      .lanes     (plan_q.data_lanes),
      .io_in     (io_in),
      .byte_next (rx_next)
   );

   assign io_out     = driven ? tx_bits : 4'b0000;
   assign io_oe      = driven ? lane_mask(tx_lanes) : 4'b0000;
   assign rd_valid   = rd_valid_q;
   assign rd_data    = rd_data_q;
   assign xip_active = xip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         plan_q     <= '0;
         addr_q     <= '0;
         beats_left <= '0;
         bytes_left <= '0;
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
         xip_q      <= 1'b0;
      end else begin
         if (rd_valid_q && rd_ready)
            rd_valid_q <= 1'b0;
         if (accept) begin
            plan_q     <= plan_c;
            addr_q     <= addr_left;
            bytes_left <= req_len;
         end
         if (phase_end) begin
            phase      <= nxt_ph;
            beats_left <= beats_of(nxt_ph, plan_s);
         end else if (beat) begin
            if (phase == PH_DATA && beats_left == 8'd1) begin
               rd_valid_q <= 1'b1;
               rd_data_q  <= rx_next;
               if (bytes_left == '0) begin
                  phase <= PH_IDLE;
                  xip_q <= plan_q.xip_next;
               end else begin
                  bytes_left <= bytes_left - 1'b1;
                  beats_left <= beats_of(PH_DATA, plan_q);
               end
            end else begin
               beats_left <= beats_left - 8'd1;
            end
         end
      end
   end

endmodule

// File: rtl/sfr_seq_chk.sv
module sfr_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       rd_valid,
   input logic       rd_ready,
   input logic [7:0] rd_data,
   input logic       cs_act,
   input logic       sck_en,
   input logic [3:0] io_oe,
   input logic       busy,
   input logic       xip_active
);

   p_accept_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> busy && cs_act);

   p_cs_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cs_act |-> busy);

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> !sck_en && io_oe == 4'b0000);

   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

   p_oe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> io_oe == 4'b0000);

   p_oe_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
      io_oe == 4'b0000 || io_oe == 4'b0001 || io_oe == 4'b0011 || io_oe == 4'b1111);

   p_xip_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(xip_active));

endmodule

bind sfr_seq sfr_seq_chk u_chk (.*);

// File: tb/sfr_seq_test.sv
`timescale 1ns/1ps
module sfr_seq_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_mode = '0;
   logic [1:0] cfg_addr_bytes = '0;
   logic       cfg_op_4b = 1'b0, cfg_op_sub = 1'b0;
   logic [7:0] cfg_opcode = '0, cfg_mode_byte = '0;
   logic [2:0] cfg_dummy = '0;
   logic       cfg_xip_en = 1'b0, cfg_turnaround = 1'b0;
   logic       req_valid = 1'b0, req_ready;
   logic [31:0] req_addr = '0;
   logic [7:0] req_len = '0;
   logic       rd_valid, rd_ready = 1'b1;
   logic [7:0] rd_data;
   logic       cs_act, sck_en, busy, xip_active;
   logic [3:0] io_out, io_oe, io_in = '0;

   int errs = 0, nchk = 0, idx = 0, ngot = 0, pseed = 0, cycles = 0;
   bit bp_on = 1'b0, xip_m = 1'b0;
   logic [3:0] obs_out [0:1023];
   logic [3:0] obs_oe  [0:1023];
   logic [7:0] got     [0:63];

   sfr_seq uut (.*);

   always #4 clk = ~clk;

   function automatic logic [3:0] pat(int i);
      return 4'((i * 7 + pseed) ^ (i >> 3));
   endfunction

   always @(negedge clk) begin
      if (sck_en) begin
         if (idx < 1024) begin
            obs_out[idx] = io_out;
            obs_oe[idx]  = io_oe;
         end
         io_in = pat(idx);
         idx++;
      end
      if (rd_valid && rd_ready) begin
         if (ngot < 64) got[ngot] = rd_data;
         ngot++;
      end
   end

   always @(posedge clk) begin
      #1;
      rd_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         errs++;
         nchk++;
         $display("FAIL R12 watchdog: actual=%0d expected=%0d", cycles, 0);
         $display("Result: errors=%0d of %0d checks", errs, nchk);
         $finish;
      end
   end

   function automatic logic [7:0] exp_op(int mode, int ab, bit op4, bit sub, logic [7:0] opc);
      logic [7:0] b;
      case (mode)
         1: b = 8'h0B;  2: b = 8'h3B;  3: b = 8'hBB;
         4: b = 8'h6B;  5: b = 8'hEB;  default: b = 8'h03;
      endcase
      if (sub) return opc;
      if (ab == 3 && op4) return (b == 8'h03) ? 8'h13 : b + 8'h01;
      return b;
   endfunction

   task automatic seg_chk(input string tag, input string what, input logic [31:0] val,
                          input int start, input int n, input int lanes);
      logic [31:0] v = val;
      logic [3:0] e;
      int mism = 0;
      for (int i = 0; i < n; i++) begin
         e = (lanes == 1) ? {3'b0, v[31]} : (lanes == 2) ? {2'b0, v[31:30]} : v[31:28];
         v = v << lanes;
         if (obs_out[start + i] !== e) mism++;
      end
      check(mism == 0, tag, what, mism, 0);
   endtask

   task automatic run_txn(input int mode, input int ab, input bit op4, input bit sub,
                          input logic [7:0] opc, input int dmy, input logic [7:0] mb,
                          input bit xen, input bit ta, input logic [31:0] addr,
                          input int len, input bit bp, input int sd);
      bit io = (mode == 3 || mode == 5);
      int al = (mode == 3) ? 2 : (mode == 5) ? 4 : 1;
      int dl = (mode == 2 || mode == 3) ? 2 : (mode >= 4) ? 4 : 1;
      bit skip = xip_m && io;
      int ncmd = skip ? 0 : 8;
      int naddr = (ab + 1) * 8 / al;
      int nmode = io ? 8 / al : 0;
      int ndum = (mode == 0) ? 0 : (dmy != 0) ? dmy + 2 : (mode == 3) ? 0 : (mode == 5) ? 4 : 8;
      int ngap = (ta && dl > 1) ? 1 : 0;
      int bpb = 8 / dl;
      int ndrv = ncmd + naddr + nmode;
      int total = ndrv + ndum + ngap + (len + 1) * bpb;
      int base = ndrv + ndum + ngap;
      int mism;
      logic [7:0] acc;
      logic [3:0] p, m;
      string otag = sub ? "R4" : (ab == 3 && op4) ? "R3" : "R2";

      @(posedge clk); #1;
      cfg_mode = 3'(mode); cfg_addr_bytes = 2'(ab); cfg_op_4b = op4; cfg_op_sub = sub;
      cfg_opcode = opc; cfg_dummy = 3'(dmy); cfg_mode_byte = mb; cfg_xip_en = xen;
      cfg_turnaround = ta; bp_on = bp; pseed = sd; idx = 0; ngot = 0;
      req_addr = addr; req_len = 8'(len); req_valid = 1'b1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      check(busy && !req_ready, "R12", "busy after accept", {busy, req_ready}, 2'b10);
      while (busy) @(negedge clk);

      if (!skip) seg_chk(otag, "opcode", {exp_op(mode, ab, op4, sub, opc), 24'd0}, 0, 8, 1);
      else check(obs_oe[0] == ((al == 2) ? 4'b0011 : 4'b1111), "R8", "no cmd in XIP",
                 obs_oe[0], (al == 2) ? 4'b0011 : 4'b1111);
      seg_chk("R5", "address", addr << (8 * (3 - ab)), ncmd, naddr, al);
      if (io) seg_chk("R7", "mode byte", {mb, 24'd0}, ncmd + naddr, nmode, al);

      mism = 0;
      for (int i = 0; i < ndrv; i++) begin
         m = (i < ncmd) ? 4'b0001 : (al == 1) ? 4'b0001 : (al == 2) ? 4'b0011 : 4'b1111;
         if (obs_oe[i] !== m) mism++;
      end
      check(mism == 0, "R1", "driven lane enables", mism, 0);

      mism = 0;
      for (int i = ndrv; i < idx && i < 1024; i++) if (obs_oe[i] !== 4'b0000) mism++;
      check(mism == 0, "R10", "enables released", mism, 0);

      check(idx == total, ngap ? "R9" : "R6", "beat count", idx, total);

      mism = 0;
      for (int k = 0; k <= len; k++) begin
         acc = '0;
         for (int j = 0; j < bpb; j++) begin
            p = pat(base + k * bpb + j);
            acc = (dl == 1) ? {acc[6:0], p[1]} : (dl == 2) ? {acc[5:0], p[1:0]} : {acc[3:0], p};
         end
         if (k < 64 && got[k] !== acc) mism++;
      end
      check(ngot == len + 1 && mism == 0, "R11", "data bytes", ngot * 256 + mism, (len + 1) * 256);

      xip_m = io && xen;
      check(xip_active == xip_m, "R8", "xip status", xip_active, xip_m);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      #1;
      check(!busy && req_ready && !cs_act && !rd_valid && !xip_active && io_oe == 4'b0000,
            "R13", "reset state", {busy, req_ready, cs_act, rd_valid, xip_active}, 5'b01000);
      #20 rst_n = 1'b1;
      @(negedge clk);
      check(!busy && req_ready && io_oe == 4'b0000, "R13", "idle after reset",
            {busy, req_ready}, 2'b01);

      run_txn(0, 2, 0, 0, 8'h00, 0, 8'h00, 0, 0, 32'h00123456, 3, 0, 1);
      run_txn(1, 2, 0, 0, 8'h00, 0, 8'h00, 0, 1, 32'h00ABCDEF, 2, 0, 2);
      run_txn(2, 2, 0, 0, 8'h00, 3, 8'h00, 0, 0, 32'h00010203, 1, 0, 3);
      run_txn(3, 2, 0, 0, 8'h00, 0, 8'hA5, 0, 1, 32'h00F0E1D2, 2, 0, 4);
      run_txn(5, 2, 0, 0, 8'h00, 0, 8'h20, 1, 0, 32'h00445566, 3, 0, 5);
      run_txn(5, 2, 0, 0, 8'h00, 0, 8'h20, 1, 1, 32'h00778899, 2, 0, 6);
      run_txn(4, 2, 0, 0, 8'h00, 0, 8'h00, 1, 1, 32'h00102030, 2, 0, 7);
      run_txn(5, 3, 1, 0, 8'h00, 2, 8'h5C, 0, 0, 32'h89ABCDEF, 1, 0, 8);
      run_txn(1, 3, 1, 1, 8'h5A, 0, 8'h00, 0, 0, 32'h01020304, 0, 0, 9);
      run_txn(3, 0, 0, 0, 8'h00, 7, 8'h3C, 0, 0, 32'h000000C3, 1, 0, 10);
      run_txn(5, 1, 0, 0, 8'h00, 0, 8'h11, 0, 1, 32'h0000BEEF, 15, 1, 11);

      for (int t = 0; t < 14; t++)
         run_txn($urandom % 6, $urandom % 4, 1'($urandom), 1'($urandom % 4 == 0),
                 8'($urandom), $urandom % 8, 8'($urandom), 1'($urandom), 1'($urandom),
                 $urandom, $urandom % 6, 1'($urandom), 100 + t);

      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
   end

endmodule